// File: doc/BRIEF.md
# Bus Turnaround Controller

This block sits between a request source and the static memory sequencer and decides how many idle cycles separate the end of one external transaction from the start of the next. When a transaction is launched, it stores the kind of that transaction: read or write, synchronous or asynchronous, which bank it targets, and whether that bank runs with multiplexed address/data or in the extended mode-D timing. That pairing of a stored record and an incoming request selects the required gap.

The gap is either the per-bank programmed turnaround value of the previous transaction's bank or a fixed value of 0, 1, 2 or 3 cycles. A fixed rule, when one matches, takes the place of the programmed value. A pending request sees `stall` high until the gap has passed. `launch` is then high for exactly one cycle, and the sequencer takes the request on that cycle. The sequencer reports the end of the access with a one-cycle `done` strobe, and the gap is counted from the cycle after that strobe.

Top module: `turnaround_ctrl`

## Requirements
- R1: After reset no previous transaction exists, so a request launches in the same cycle it is presented, with `stall` low.
- R2: `launch` is high only while `req_valid` is high, and never in two consecutive cycles. After a launch and until the following `done`, no launch occurs. `stall` is high exactly when `req_valid` is high and `launch` is low.
- R3: If `done` is high in cycle T and the required gap is D, a request held from cycle T+1 launches in cycle T+1+D. A request that first appears g cycles after T+1 launches after max(0, D-g) cycles.
- R4: An asynchronous write followed by a write to the same bank, with the previous access not multiplexed/mode D (`req_muxd`=0), gets a gap of 0.
- R5: After an asynchronous, non-multiplexed write, a read to any bank or a write to a different bank gets the programmed value of the previous bank. Bank i's 4-bit value sits at `turn_cfg[4*i+3:4*i]`.
- R6: After an asynchronous, non-multiplexed read, a read to the same bank gets 1 cycle, a write to any bank (synchronous or not) gets 1 cycle, and a read to another bank gets 0.
- R7: After any asynchronous access with `req_muxd`=1, every following request gets the programmed value of that bank.
- R8: After a synchronous write, the gap is 2 cycles for a synchronous write to the same bank and for any asynchronous read or write.
- R9: After a synchronous write, the gap is 3 cycles for a synchronous write to a different bank and for any synchronous read.
- R10: After a synchronous read, the gap to any following request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is pending and held until launched |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_sync | input | 1 | Request is synchronous (1) or asynchronous (0) |
| req_muxd | input | 1 | Target bank uses multiplexed or mode-D timing |
| req_bank | input | BANK_W | Target bank index |
| turn_cfg | input | NUM_BANKS*TURN_W | Programmed turnaround value per bank, bank 0 in the low bits |
| done | input | 1 | One-cycle strobe from the sequencer at the end of the launched access |
| stall | output | 1 | Pending request is being held back |
| launch | output | 1 | One-cycle strobe that hands the request to the sequencer |

## Verification
Requests are run in chains in which each transaction becomes the previous one for the next. The chains visit every combination of read/write, synchronous/asynchronous, same/different bank and multiplexed/plain that has its own rule, so that a fixed delay which wrongly overrides the programmed one, or the reverse, shows up as a different launch cycle. The per-bank values are set to distinct numbers (5, 2, 15, 0), so a lookup that reads the wrong bank's value is exposed. Requests that arrive late, after part of the gap has already passed, separate a counter that starts on the completion strobe from one that starts at the request. A request held high while an access is in flight, and a reset in the middle of the run, cover the single-launch and no-history cases.

// File: rtl/turnaround_pkg.sv
package turnaround_pkg;

   typedef enum logic [1:0] {
      PH_FRESH = 2'd0,
      PH_BUSY  = 2'd1,
      PH_GAP   = 2'd2
   } phase_t;

   typedef struct packed {
      logic wr;
      logic syn;
      logic mx;
   } kind_t;

   localparam int unsigned FIX_ONE   = 1;
   localparam int unsigned FIX_TWO   = 2;
   localparam int unsigned FIX_THREE = 3;

endpackage

// File: rtl/ta_history.sv
module ta_history
   import turnaround_pkg::*;
#(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              done_i,
   input  kind_t             kind_i,
   input  logic [BANK_W-1:0] bank_i,
   output phase_t            phase_o,
   output kind_t             kind_o,
   output logic [BANK_W-1:0] bank_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_o <= PH_FRESH;
         kind_o  <= '0;
         bank_o  <= '0;
      end else if (launch_i) begin
         phase_o <= PH_BUSY;
         kind_o  <= kind_i;
         bank_o  <= bank_i;
      end else if (phase_o == PH_BUSY && done_i) begin
         phase_o <= PH_GAP;
      end
   end

endmodule

// File: rtl/ta_gap_timer.sv
module ta_gap_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] elapsed_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_o <= '0;
      end else if (restart_i) begin
         elapsed_o <= '0;
      end else if (run_i && elapsed_o != CNT_MAX) begin
         elapsed_o <= elapsed_o + 1'b1;
      end
   end

endmodule

// File: rtl/ta_rule_sel.sv
module ta_rule_sel
   import turnaround_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int TURN_W = 4,
   parameter int CNT_W  = 4
) (
   input  kind_t             prev_kind_i,
   input  logic [BANK_W-1:0] prev_bank_i,
   input  logic [TURN_W-1:0] prog_i,
   input  kind_t             next_kind_i,
   input  logic [BANK_W-1:0] next_bank_i,
   output logic [CNT_W-1:0]  need_o
);

   logic same_bank;
   assign same_bank = (prev_bank_i == next_bank_i);

   always_comb begin
      need_o = '0;
      if (!prev_kind_i.syn) begin
         if (prev_kind_i.mx) begin
            need_o = CNT_W'(prog_i);
         end else if (prev_kind_i.wr) begin
            if (!(next_kind_i.wr && same_bank)) need_o = CNT_W'(prog_i);
         end else if (next_kind_i.wr || same_bank) begin
            need_o = CNT_W'(FIX_ONE);
         end
      end else if (prev_kind_i.wr) begin
         if (!next_kind_i.syn) begin
            need_o = CNT_W'(FIX_TWO);
         end else if (next_kind_i.wr && same_bank) begin
            need_o = CNT_W'(FIX_TWO);
         end else begin
            need_o = CNT_W'(FIX_THREE);
         end
      end
   end

endmodule

// File: rtl/turnaround_ctrl.sv
module turnaround_ctrl
   import turnaround_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int TURN_W    = 4,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic                        req_sync,
   input  logic                        req_muxd,
   input  logic [BANK_W-1:0]           req_bank,
   input  logic [NUM_BANKS*TURN_W-1:0] turn_cfg,
   input  logic                        done,
   output logic                        stall,
   output logic                        launch
);

   localparam int CNT_W = TURN_W;

   if (TURN_W < 2) begin : g_bad_turn_w
      $error("TURN_W must hold the fixed gap of 3");
   end
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end

   phase_t            phase;
   kind_t             prev_kind;
   kind_t             next_kind;
   logic [BANK_W-1:0] prev_bank;
   logic [CNT_W-1:0]  elapsed;
   logic [CNT_W-1:0]  need;
   logic [TURN_W-1:0] prog;
   logic              gate_open;
   logic              access_end;
   logic [TURN_W-1:0] cfg_arr [NUM_BANKS];

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cfg
      assign cfg_arr[g] = turn_cfg[g*TURN_W +: TURN_W];
   end

   assign prog       = cfg_arr[prev_bank];
   assign next_kind  = '{wr: req_write, syn: req_sync, mx: req_muxd};
   assign access_end = (phase == PH_BUSY) && done;

   ta_history #(.BANK_W(BANK_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .done_i   (done),
      .kind_i   (next_kind),
      .bank_i   (req_bank),
      .phase_o  (phase),
      .kind_o   (prev_kind),
      .bank_o   (prev_bank)
   );

   ta_gap_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (access_end),
      .run_i     (phase == PH_GAP),
      .elapsed_o (elapsed)
   );

   ta_rule_sel #(.BANK_W(BANK_W), .TURN_W(TURN_W), .CNT_W(CNT_W)) u_rule (
      .prev_kind_i (prev_kind),
      .prev_bank_i (prev_bank),
      .prog_i      (prog),
      .next_kind_i (next_kind),
      .next_bank_i (req_bank),
      .need_o      (need)
   );

   assign gate_open = (phase == PH_FRESH) || (phase == PH_GAP && elapsed >= need);
   assign launch    = req_valid && gate_open;
   assign stall     = req_valid && !gate_open;

endmodule

// File: rtl/turnaround_ctrl_chk.sv
module turnaround_ctrl_chk #(
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_sync,
   input logic              req_muxd,
   input logic [BANK_W-1:0] req_bank,
   input logic              done,
   input logic              stall,
   input logic              launch
);

   logic              seen;
   logic              inflight;
   logic              c_wr;
   logic              c_syn;
   logic              c_mx;
   logic [BANK_W-1:0] c_bank;
   logic [7:0]        since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         inflight <= 1'b0;
         c_wr     <= 1'b0;
         c_syn    <= 1'b0;
         c_mx     <= 1'b0;
         c_bank   <= '0;
         since    <= '0;
      end else begin
         if (launch) begin
            seen     <= 1'b1;
            inflight <= 1'b1;
            c_wr     <= req_write;
            c_syn    <= req_sync;
            c_mx     <= req_muxd;
            c_bank   <= req_bank;
         end else if (inflight && done) begin
            inflight <= 1'b0;
            since    <= '0;
         end else if (!inflight && since != 8'hFF) begin
            since <= since + 8'd1;
         end
      end
   end

   assert_first_req_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen && req_valid) |-> launch);

   assert_no_launch_inflight_R2: assert property (@(posedge clk) disable iff (!rst_n)
      inflight |-> !launch);

   assert_stall_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> req_valid);

   assert_same_bank_write_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !inflight && since == 8'd0 && c_wr && !c_syn && !c_mx &&
       req_valid && req_write && req_bank == c_bank) |-> launch);

   assert_sync_write_min_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && seen && c_wr && c_syn) |-> since >= 8'd2);

   assert_sync_write_min_three_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && seen && c_wr && c_syn && req_sync &&
       !(req_write && req_bank == c_bank)) |-> since >= 8'd3);

endmodule

bind turnaround_ctrl turnaround_ctrl_chk #(.BANK_W(BANK_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_sync  (req_sync),
   .req_muxd  (req_muxd),
   .req_bank  (req_bank),
   .done      (done),
   .stall     (stall),
   .launch    (launch)
);

// File: tb/turnaround_ctrl_test.sv
`timescale 1ns/1ps
module turnaround_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic       req_sync = 1'b0;
   logic       req_muxd = 1'b0;
   logic [1:0] req_bank = 2'd0;
   logic [15:0] turn_cfg;
   logic       done = 1'b0;
   logic       stall;
   logic       launch;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int cfg_val [4];

   // reference model state
   bit    m_busy = 1'b0;
   bit    m_has_prev = 1'b0;
   int    m_elapsed = 0;
   bit    m_pw, m_ps, m_pm;
   int    m_pb;

   always #2.5 clk = ~clk;

   turnaround_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_sync  (req_sync),
      .req_muxd  (req_muxd),
      .req_bank  (req_bank),
      .turn_cfg  (turn_cfg),
      .done      (done),
      .stall     (stall),
      .launch    (launch)
   );

   // gap required by the requirements for previous -> next
   function automatic int rule_delay(input bit pw, input bit ps, input bit pm, input int pb,
                                     input bit nw, input bit ns, input int nb,
                                     output string tag);
      if (!ps && pm) begin
         tag = "R7"; return cfg_val[pb];
      end
      if (!ps && pw) begin
         if (nw && nb == pb) begin tag = "R4"; return 0; end
         tag = "R5"; return cfg_val[pb];
      end
      if (!ps) begin
         tag = "R6";
         if (nw) return 1;
         return (nb == pb) ? 1 : 0;
      end
      if (pw) begin
         if (!ns) begin tag = "R8"; return 2; end
         if (nw && nb == pb) begin tag = "R8"; return 2; end
         tag = "R9"; return 3;
      end
      tag = "R10";
      return 0;
   endfunction

   always @(negedge clk) begin
      bit    e_launch;
      bit    e_stall;
      string tag;
      int    d;
      if (!rst_n) begin
         m_busy = 0; m_has_prev = 0; m_elapsed = 0;
         tests++;
         if (stall !== 1'b0 || launch !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset: stall=%b launch=%b expected 0 0", stall, launch);
         end
      end else begin
         if (m_busy) begin
            e_launch = 0; tag = "R2";
         end else if (!m_has_prev) begin
            e_launch = req_valid; tag = "R1";
         end else begin
            d = rule_delay(m_pw, m_ps, m_pm, m_pb, req_write, req_sync, int'(req_bank), tag);
            e_launch = req_valid && (m_elapsed >= d);
            if (req_valid) tag = {tag, "/R3"};
         end
         e_stall = req_valid && !e_launch;
         tests++;
         if (launch !== e_launch || stall !== e_stall) begin
            fails++;
            $display("FAIL %s cycle %0d: launch=%b stall=%b expected launch=%b stall=%b",
                     tag, cycles, launch, stall, e_launch, e_stall);
         end
         if (e_launch) begin
            m_busy = 1; m_has_prev = 1;
            m_pw = req_write; m_ps = req_sync; m_pm = req_muxd; m_pb = int'(req_bank);
         end else if (m_busy && done) begin
            m_busy = 0; m_elapsed = 0;
         end else if (!m_busy && m_elapsed < 15) begin
            m_elapsed++;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 20000) begin
         fails++;
         $display("FAIL watchdog: run did not end, cycles=%0d expected below 20000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
         $finish;
      end
   end

   task automatic run_txn(input bit w, input bit s, input bit m, input int b,
                          input int pre_gap, input int exp_k, input string tag,
                          input bit poke);
      int k;
      repeat (pre_gap) @(posedge clk);
      #1;
      req_write = w; req_sync = s; req_muxd = m; req_bank = 2'(b); req_valid = 1'b1;
      k = 0;
      forever begin
         @(negedge clk);
         if (launch === 1'b1) break;
         k++;
         if (k > 40) break;
      end
      tests++;
      if (k != exp_k) begin
         fails++;
         $display("FAIL %s: launch after %0d cycles, expected %0d", tag, k, exp_k);
      end
      @(posedge clk); #1;
      if (poke) begin
         req_bank = 2'(b + 1);
      end else begin
         req_valid = 1'b0;
      end
      @(posedge clk);
      if (poke) begin
         @(negedge clk);
         tests++;
         if (launch !== 1'b0 || stall !== 1'b1) begin
            fails++;
            $display("FAIL R2 in flight: launch=%b stall=%b expected launch=0 stall=1",
                     launch, stall);
         end
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
      done = 1'b1;
      @(posedge clk); #1;
      done = 1'b0;
   endtask

   initial begin
      cfg_val[0] = 5; cfg_val[1] = 2; cfg_val[2] = 15; cfg_val[3] = 0;
      turn_cfg = {4'd0, 4'd15, 4'd2, 4'd5};
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // args: write, sync, muxd, bank, pre_gap, expected gap, tag, poke
      run_txn(1, 0, 0, 0, 0, 0,  "R1 first request", 0);
      run_txn(1, 0, 0, 0, 0, 0,  "R4 async wr->wr same bank", 0);
      run_txn(0, 0, 0, 1, 0, 5,  "R5 async wr->rd, bank0 value", 0);
      run_txn(0, 0, 0, 1, 0, 1,  "R6 async rd->rd same bank", 0);
      run_txn(1, 1, 0, 2, 0, 1,  "R6 async rd->sync wr", 0);
      run_txn(1, 1, 0, 2, 0, 2,  "R8 sync wr->sync wr same bank", 0);
      run_txn(1, 1, 0, 3, 0, 3,  "R9 sync wr->sync wr other bank", 0);
      run_txn(0, 0, 0, 0, 0, 2,  "R8 sync wr->async rd", 0);
      run_txn(0, 0, 0, 3, 0, 0,  "R6 async rd->rd other bank", 1);
      run_txn(1, 0, 0, 2, 0, 1,  "R6 async rd->wr other bank", 0);
      run_txn(1, 0, 1, 1, 0, 15, "R5 async wr->wr other bank, bank2 value", 0);
      run_txn(1, 0, 1, 1, 0, 2,  "R7 muxed wr->wr same bank", 0);
      run_txn(0, 0, 1, 1, 0, 2,  "R7 muxed wr->rd", 0);
      run_txn(0, 0, 0, 1, 0, 2,  "R7 muxed rd->rd same bank", 0);
      run_txn(1, 1, 0, 0, 0, 1,  "R6 async rd->sync wr other bank", 0);
      run_txn(0, 1, 0, 1, 0, 3,  "R9 sync wr->sync rd", 0);
      run_txn(1, 0, 0, 1, 0, 0,  "R10 sync rd->async wr", 0);
      run_txn(0, 0, 0, 2, 3, 0,  "R3 late request covers gap", 0);
      run_txn(1, 0, 0, 2, 0, 1,  "R6 async rd->wr same bank", 0);
      run_txn(1, 0, 0, 3, 4, 11, "R3 late request, partial gap", 0);
      run_txn(1, 1, 0, 3, 0, 0,  "R4 async wr->sync wr same bank", 0);
      run_txn(0, 0, 0, 0, 1, 1,  "R3 sync wr->async rd after 1 idle", 0);

      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      run_txn(0, 1, 0, 2, 0, 0,  "R1 first request after reset", 0);

      repeat (3) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule